// File: doc/BRIEF.md
# Dual-Port Inter-Processor Message Box

This block lets two processors, called side A and side B, pass 32-bit words to each other through a shared set of registers. Each side has its own word-wide register port (write strobe, read strobe, address, write data, read data) and its own interrupt line. The block holds eight channels. Each channel is a four-entry queue that carries words one way only. Side A alone decides which way each channel carries words.

The sender writes a channel's data register to queue a word. The receiver reads the same register to take the oldest word out. Each side has an interrupt enable register and an interrupt status register, with two bits per channel. The receive bit tells the receiver that data has arrived. It cannot be cleared while the queue still holds words. Each side can also read the other side's enable and status registers. A sender therefore sees that its message has been consumed once the receiver has drained the queue and cleared its receive bit.

Top module: `ipcMailbox`

## Requirements
- R1: After reset, every channel carries words from B to A, all queues are empty, both enable registers read 0 and both interrupt outputs are low.
- R2: The direction words sit at word offsets 0x00 (channels 0-3) and 0x04 (channels 4-7). For channel n, bit 4+8*(n%4) reads 1 on the side that sends and bit 8*(n%4) reads 1 on the side that receives. A write from A sets channel n to A-sends when bit 4+8*(n%4) is 1, and to B-sends when it is 0. Writes from B to these words have no effect.
- R3: For channel n, the data register is at 0x180+4n. A write by the sender appends a word. A read by the receiver returns the oldest word and removes it. Words leave in the order they arrived, up to four at a time.
- R4: Bit 0 of offset 0x100+4n reads 1 exactly when channel n holds four words. A write to a full queue is dropped.
- R5: Bits 2:0 of offset 0x140+4n give the number of queued words (0-4). A receiver read of an empty queue returns 0 and leaves the count at 0.
- R6: A data write by the receiving side, or a data read by the sending side, leaves the queue unchanged, and that read returns 0. Reads of unmapped offsets return 0.
- R7: Status bit 2n (local status at 0x70) is 1 on the receiving side once a word has arrived. Writing 1 to it clears it only if the queue is empty in that cycle and no word arrives in that cycle. On the sending side the bit reads 0.
- R8: Status bit 2n+1 reads 1 on the sending side while channel n is not full, and 0 on the receiving side. Writing to it has no effect.
- R9: The local enable register (0x60, 16 bits) can be read and written. Each side's interrupt output equals the OR over all bits of its status AND its enable.
- R10: Offset 0x40 reads the other side's enable register and 0x50 reads the other side's status. Writes to either offset have no effect.
- R11: When the sender pushes and the receiver pops the same channel in one cycle, both take effect. The count is unchanged and the oldest word is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aWrEn | input | 1 | Side A write strobe |
| aRdEn | input | 1 | Side A read strobe (pops on a data read) |
| aAddr | input | 12 | Side A byte address |
| aWrData | input | 32 | Side A write data |
| aRdData | output | 32 | Side A read data, valid in the cycle of the read |
| aIrq | output | 1 | Side A interrupt |
| bWrEn | input | 1 | Side B write strobe |
| bRdEn | input | 1 | Side B read strobe (pops on a data read) |
| bAddr | input | 12 | Side B byte address |
| bWrData | input | 32 | Side B write data |
| bRdData | output | 32 | Side B read data, valid in the cycle of the read |
| bIrq | output | 1 | Side B interrupt |

## Verification
Read data is a decode of the current state, so it is due in the same cycle as the read strobe. The bench drives each access just after a falling edge and samples the read data 1 ns later, before the rising edge that performs any pop. Queue contents, counts, status bits and directions change at the rising edge that ends the access. The interrupt outputs depend only on registers, so the bench compares them with its model 1 ns after that edge. Its model computes every read value from the state before the access and applies all effects of an access together, so simultaneous accesses from both sides are predicted the way the block resolves them.

// File: rtl/ipcMbPkg.sv
package ipcMbPkg;
  localparam int CH     = 8;
  localparam int DEPTH  = 4;
  localparam int DW     = 32;
  localparam int AW     = 12;
  localparam int SIDES  = 2;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ST_W   = 2 * CH;
  localparam int NGRP   = (CH + 3) / 4;

  typedef enum logic [3:0] {
    RG_NONE, RG_DIR, RG_REN, RG_RST, RG_LEN, RG_LST, RG_FULL, RG_CNT, RG_DATA
  } region_e;

  typedef struct packed {
    logic [CH-1:0]              push;
    logic [CH-1:0]              pop;
    logic [CH-1:0]              dirLoad;
    logic [CH-1:0]              dirVal;
    logic [SIDES-1:0]           enWr;
    logic [SIDES-1:0][ST_W-1:0] w1c;
  } mbStrobes_t;
endpackage

// File: rtl/mbFifo.sv
module mbFifo
  import ipcMbPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    din,
  output logic [CNT_W-1:0] fill,
  output logic [DW-1:0]    head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][DW-1:0] mem;
  logic [PTR_W-1:0] rdPtr, wrPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign head = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
      mem   <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= din;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (pop) rdPtr <= nextPtr(rdPtr);
      if (push && !pop) fill <= fill + 1'b1;
      else if (pop && !push) fill <= fill - 1'b1;
    end
  end

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(fill) <= DEPTH);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> int'(fill) != DEPTH);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> fill != '0);
  // R11
  fill_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> fill == $past(fill) + CNT_W'($past(push)) - CNT_W'($past(pop)));
endmodule

// File: rtl/mbCtrl.sv
module mbCtrl
  import ipcMbPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SIDES-1:0]            wrEn,
  input  logic [SIDES-1:0]            rdEn,
  input  logic [SIDES-1:0][AW-1:0]    addr,
  input  logic [SIDES-1:0][DW-1:0]    wrData,
  input  logic [CH-1:0]               aSends,
  input  logic [CH-1:0][CNT_W-1:0]    fill,
  input  logic [CH-1:0][DW-1:0]       head,
  input  logic [SIDES-1:0][ST_W-1:0]  status,
  input  logic [SIDES-1:0][ST_W-1:0]  intEn,
  output mbStrobes_t                  strb,
  output logic [SIDES-1:0][DW-1:0]    rdData
);
  function automatic region_e decode(input logic [AW-1:0] a);
    logic [AW-3:0] w;
    w = a[AW-1:2];
    if (int'(w) < NGRP) return RG_DIR;
    if (w == (AW-2)'('h10)) return RG_REN;
    if (w == (AW-2)'('h14)) return RG_RST;
    if (w == (AW-2)'('h18)) return RG_LEN;
    if (w == (AW-2)'('h1C)) return RG_LST;
    if (w[AW-3:6] == (AW-8)'(1) && int'(w[3:0]) < CH) begin
      case (w[5:4])
        2'd0:    return RG_FULL;
        2'd1:    return RG_CNT;
        2'd2:    return RG_DATA;
        default: return RG_NONE;
      endcase
    end
    return RG_NONE;
  endfunction

  always_comb begin
    region_e rg;
    int      sel;
    logic    mine;
    logic    isFull;
    strb   = '0;
    rdData = '0;
    for (int s = 0; s < SIDES; s++) begin
      rg  = decode(addr[s]);
      sel = int'(addr[s][AW-1:2]);
      if (rg == RG_FULL || rg == RG_CNT || rg == RG_DATA) sel = int'(addr[s][5:2]);
      unique case (rg)
        RG_REN: rdData[s][ST_W-1:0] = intEn[SIDES-1-s];
        RG_RST: rdData[s][ST_W-1:0] = status[SIDES-1-s];
        RG_LEN: rdData[s][ST_W-1:0] = intEn[s];
        RG_LST: rdData[s][ST_W-1:0] = status[s];
        default: ;
      endcase
      if (rg == RG_LEN && wrEn[s]) strb.enWr[s] = 1'b1;
      if (rg == RG_LST && wrEn[s]) strb.w1c[s] = wrData[s][ST_W-1:0];
      for (int c = 0; c < CH; c++) begin
        mine   = (aSends[c] == (s == 0));
        isFull = (int'(fill[c]) == DEPTH);
        if (rg == RG_DIR && c / 4 == sel) begin
          rdData[s][8*(c%4)]   = !mine;
          rdData[s][4+8*(c%4)] = mine;
          if (s == 0 && wrEn[s]) begin
            strb.dirLoad[c] = 1'b1;
            strb.dirVal[c]  = wrData[s][4+8*(c%4)];
          end
        end
        if (c == sel) begin
          if (rg == RG_FULL) rdData[s][0] = isFull;
          if (rg == RG_CNT)  rdData[s][CNT_W-1:0] = fill[c];
          if (rg == RG_DATA) begin
            if (!mine && fill[c] != '0) begin
              rdData[s] = head[c];
              if (rdEn[s]) strb.pop[c] = 1'b1;
            end
            if (mine && wrEn[s] && !isFull) strb.push[c] = 1'b1;
          end
        end
      end
    end
  end

  // R2
  dir_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dirLoad != '0) |-> wrEn[0]);
  // R6
  pop_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop != '0) |-> (rdEn != '0));
endmodule

// File: rtl/mbDatapath.sv
module mbDatapath
  import ipcMbPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  mbStrobes_t                  strb,
  input  logic [SIDES-1:0][DW-1:0]    wrData,
  output logic [CH-1:0]               aSends,
  output logic [CH-1:0][CNT_W-1:0]    fill,
  output logic [CH-1:0][DW-1:0]       head,
  output logic [SIDES-1:0][ST_W-1:0]  status,
  output logic [SIDES-1:0][ST_W-1:0]  intEn,
  output logic [SIDES-1:0]            irq
);
  logic [CH-1:0] rxPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aSends <= '0;
      intEn  <= '0;
    end else begin
      for (int c = 0; c < CH; c++)
        if (strb.dirLoad[c]) aSends[c] <= strb.dirVal[c];
      for (int s = 0; s < SIDES; s++)
        if (strb.enWr[s]) intEn[s] <= wrData[s][ST_W-1:0];
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_chan
    logic clrHit;
    logic notFull;

    mbFifo u_fifo (
      .clk  (clk),
      .rstN (rstN),
      .push (strb.push[c]),
      .pop  (strb.pop[c]),
      .din  (aSends[c] ? wrData[0] : wrData[1]),
      .fill (fill[c]),
      .head (head[c])
    );

    assign clrHit  = aSends[c] ? strb.w1c[1][2*c] : strb.w1c[0][2*c];
    assign notFull = int'(fill[c]) != DEPTH;

    always_ff @(posedge clk) begin
      if (!rstN) rxPend[c] <= 1'b0;
      else if (strb.push[c]) rxPend[c] <= 1'b1;
      else if (clrHit && fill[c] == '0) rxPend[c] <= 1'b0;
    end

    assign status[0][2*c]   = rxPend[c] & ~aSends[c];
    assign status[0][2*c+1] = notFull & aSends[c];
    assign status[1][2*c]   = rxPend[c] & aSends[c];
    assign status[1][2*c+1] = notFull & ~aSends[c];

    // R7
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fill[c] != '0) |-> rxPend[c]);
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_irq
    assign irq[s] = |(status[s] & intEn[s]);
    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (intEn[s] == '0) |-> !irq[s]);
  end
endmodule

// File: rtl/ipcMailbox.sv
module ipcMailbox
  import ipcMbPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          aWrEn,
  input  logic          aRdEn,
  input  logic [AW-1:0] aAddr,
  input  logic [DW-1:0] aWrData,
  output logic [DW-1:0] aRdData,
  output logic          aIrq,
  input  logic          bWrEn,
  input  logic          bRdEn,
  input  logic [AW-1:0] bAddr,
  input  logic [DW-1:0] bWrData,
  output logic [DW-1:0] bRdData,
  output logic          bIrq
);
  mbStrobes_t                 strb;
  logic [SIDES-1:0]           wrEn, rdEn, irq;
  logic [SIDES-1:0][AW-1:0]   addr;
  logic [SIDES-1:0][DW-1:0]   wrData, rdData;
  logic [CH-1:0]              aSends;
  logic [CH-1:0][CNT_W-1:0]   fill;
  logic [CH-1:0][DW-1:0]      head;
  logic [SIDES-1:0][ST_W-1:0] status, intEn;

  assign wrEn   = {bWrEn, aWrEn};
  assign rdEn   = {bRdEn, aRdEn};
  assign addr   = {bAddr, aAddr};
  assign wrData = {bWrData, aWrData};
  assign aRdData = rdData[0];
  assign bRdData = rdData[1];
  assign aIrq    = irq[0];
  assign bIrq    = irq[1];

  mbCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .aSends (aSends),
    .fill   (fill),
    .head   (head),
    .status (status),
    .intEn  (intEn),
    .strb   (strb),
    .rdData (rdData)
  );

  mbDatapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .aSends (aSends),
    .fill   (fill),
    .head   (head),
    .status (status),
    .intEn  (intEn),
    .irq    (irq)
  );
endmodule

// File: tb/ipcMailbox_tb.sv
module ipcMailbox_tb;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aWrEn = 0, aRdEn = 0, bWrEn = 0, bRdEn = 0;
  logic [11:0] aAddr = '0, bAddr = '0;
  logic [31:0] aWrData = '0, bWrData = '0;
  logic [31:0] aRdData, bRdData;
  logic aIrq, bIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ipcMailbox u_dut (
    .clk(clk), .rstN(rstN),
    .aWrEn(aWrEn), .aRdEn(aRdEn), .aAddr(aAddr), .aWrData(aWrData),
    .aRdData(aRdData), .aIrq(aIrq),
    .bWrEn(bWrEn), .bRdEn(bRdEn), .bAddr(bAddr), .bWrData(bWrData),
    .bRdData(bRdData), .bIrq(bIrq)
  );

  // reference model state
  logic [31:0] mq [NC][$];
  logic [NC-1:0] mDirA = '0;
  logic [NC-1:0] mPend = '0;
  logic [15:0] mEn [2] = '{16'h0, 16'h0};

  function automatic int sender(int c);
    return mDirA[c] ? 0 : 1;
  endfunction

  function automatic logic [15:0] mStat(int s);
    logic [15:0] r = '0;
    for (int c = 0; c < NC; c++) begin
      if (sender(c) != s && mPend[c]) r[2*c] = 1'b1;
      if (sender(c) == s && mq[c].size() < 4) r[2*c+1] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] mRead(int s, logic [11:0] a);
    logic [31:0] r = '0;
    int w = int'(a[11:2]);
    int c = int'(a[5:2]);
    if (w < 2) begin
      for (int k = 0; k < 4; k++) begin
        r[8*k]   = (sender(w*4+k) != s);
        r[4+8*k] = (sender(w*4+k) == s);
      end
    end else if (w == 'h10) r[15:0] = mEn[1-s];
    else if (w == 'h14) r[15:0] = mStat(1-s);
    else if (w == 'h18) r[15:0] = mEn[s];
    else if (w == 'h1C) r[15:0] = mStat(s);
    else if (w >= 'h40 && w < 'h48) r[0] = (mq[c].size() == 4);
    else if (w >= 'h50 && w < 'h58) r[2:0] = 3'(mq[c].size());
    else if (w >= 'h60 && w < 'h68) begin
      if (sender(c) != s && mq[c].size() > 0) r = mq[c][0];
    end
    return r;
  endfunction

  function automatic string tagOf(logic [11:0] a);
    int w = int'(a[11:2]);
    if (w < 2) return "R2";
    if (w == 'h10 || w == 'h14) return "R10";
    if (w == 'h18) return "R9";
    if (w == 'h1C) return "R7 R8";
    if (w >= 'h40 && w < 'h48) return "R4";
    if (w >= 'h50 && w < 'h58) return "R5";
    if (w >= 'h60 && w < 'h68) return "R3";
    return "R6";
  endfunction

  task automatic mApply(int aOp, logic [11:0] aA, logic [31:0] aD,
                        int bOp, logic [11:0] bA, logic [31:0] bD);
    int pre [NC];
    logic [NC-1:0] nDir = mDirA;
    logic [NC-1:0] pushed = '0;
    logic [NC-1:0] clr = '0;
    logic [31:0] pd [NC];
    int op; logic [11:0] a; logic [31:0] d; int w; int c;
    for (int i = 0; i < NC; i++) begin pre[i] = mq[i].size(); pd[i] = '0; end
    for (int s = 0; s < 2; s++) begin
      op = s == 0 ? aOp : bOp;
      a  = s == 0 ? aA : bA;
      d  = s == 0 ? aD : bD;
      w  = int'(a[11:2]);
      c  = int'(a[5:2]);
      if (op == 1) begin
        if (w < 2 && s == 0)
          for (int k = 0; k < 4; k++) nDir[w*4+k] = d[4+8*k];
        if (w == 'h18) mEn[s] = d[15:0];
        if (w == 'h1C)
          for (int i = 0; i < NC; i++)
            if (sender(i) != s && d[2*i]) clr[i] = 1'b1;
        if (w >= 'h60 && w < 'h68 && sender(c) == s && pre[c] < 4) begin
          pushed[c] = 1'b1; pd[c] = d;
        end
      end else if (op == 2) begin
        if (w >= 'h60 && w < 'h68 && sender(c) != s && pre[c] > 0)
          void'(mq[c].pop_front());
      end
    end
    for (int i = 0; i < NC; i++) begin
      if (pushed[i]) begin mq[i].push_back(pd[i]); mPend[i] = 1'b1; end
      else if (clr[i] && pre[i] == 0) mPend[i] = 1'b0;
    end
    mDirA = nDir;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tg, int aOp, logic [11:0] aA, logic [31:0] aD,
                      int bOp, logic [11:0] bA, logic [31:0] bD);
    logic [31:0] expA, expB;
    @(negedge clk);
    aWrEn = (aOp == 1); aRdEn = (aOp == 2); aAddr = aA; aWrData = aD;
    bWrEn = (bOp == 1); bRdEn = (bOp == 2); bAddr = bA; bWrData = bD;
    #1;
    expA = mRead(0, aA);
    expB = mRead(1, bA);
    if (aOp == 2) chk(tg != "" ? tg : tagOf(aA), aRdData, expA);
    if (bOp == 2) chk(tg != "" ? tg : tagOf(bA), bRdData, expB);
    mApply(aOp, aA, aD, bOp, bA, bD);
    @(posedge clk); #1;
    aWrEn = 0; aRdEn = 0; bWrEn = 0; bRdEn = 0;
    chk("R9", {31'b0, aIrq}, {31'b0, |(mStat(0) & mEn[0])});
    chk("R9", {31'b0, bIrq}, {31'b0, |(mStat(1) & mEn[1])});
  endtask

  function automatic logic [11:0] randAddr();
    int c = int'($urandom % NC);
    case ($urandom % 11)
      0:  return 12'(($urandom % 2) * 4);
      1:  return 12'h040;
      2:  return 12'h050;
      3:  return 12'h060;
      4:  return 12'h070;
      5:  return 12'(12'h100 + 4*c);
      6:  return 12'(12'h140 + 4*c);
      7:  return 12'h200;
      default: return 12'(12'h180 + 4*c);
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1", {31'b0, aIrq}, 32'd0);
    chk("R1", {31'b0, bIrq}, 32'd0);
    step("R1", 2, 12'h000, 0, 2, 12'h004, 0);
    step("R1", 2, 12'h060, 0, 2, 12'h060, 0);
    step("R1", 2, 12'h140, 0, 2, 12'h15C, 0);
    // R2: A sets ch0, ch1 A-sends; B write ignored
    step("", 1, 12'h000, 32'h0000_1010, 1, 12'h004, 32'hFFFF_FFFF);
    step("R2", 2, 12'h000, 0, 2, 12'h000, 0);
    step("R2", 2, 12'h004, 0, 2, 12'h004, 0);
    // R3 R4: fill ch0 to full, fifth dropped
    for (int i = 0; i < 5; i++) step("", 1, 12'h180, 32'hA000_0000 + i, 0, 0, 0);
    step("R4", 2, 12'h100, 0, 2, 12'h100, 0);
    step("R5", 2, 12'h140, 0, 0, 0, 0);
    // R6: wrong-direction accesses
    step("", 0, 0, 0, 1, 12'h180, 32'hDEAD_BEEF);
    step("R6", 2, 12'h180, 0, 2, 12'h140, 0);
    // R7: clear fails while non-empty
    step("", 0, 0, 0, 1, 12'h070, 32'h0000_FFFF);
    step("R7", 0, 0, 0, 2, 12'h070, 0);
    // R9 R10: B enables receive bit of ch0, A snoops
    step("", 0, 0, 0, 1, 12'h060, 32'h0000_0001);
    step("R10", 2, 12'h050, 0, 0, 0, 0);
    step("", 1, 12'h040, 32'hFFFF, 0, 0, 0);
    step("R10", 2, 12'h040, 0, 2, 12'h060, 0);
    // R3: drain in order, then empty read (R5)
    for (int i = 0; i < 4; i++) step("R3", 0, 0, 0, 2, 12'h180, 0);
    step("R5", 0, 0, 0, 2, 12'h180, 0);
    step("R5", 0, 0, 0, 2, 12'h140, 0);
    step("R8", 2, 12'h070, 0, 0, 0, 0);
    step("", 0, 0, 0, 1, 12'h070, 32'h0000_0001);
    step("R7", 0, 0, 0, 2, 12'h070, 0);
    // R11: simultaneous push and pop
    step("", 1, 12'h180, 32'h1111_0001, 0, 0, 0);
    step("", 1, 12'h180, 32'h1111_0002, 0, 0, 0);
    step("R11", 1, 12'h180, 32'h1111_0003, 2, 12'h180, 0);
    step("R11", 2, 12'h140, 0, 2, 12'h180, 0);
    step("R11", 2, 12'h140, 0, 0, 0, 0);
    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] aa = randAddr();
      logic [11:0] ba = randAddr();
      int ao = int'($urandom % 3);
      int bo = int'($urandom % 3);
      if (aa < 12'h008 && ao == 1 && ($urandom % 4) != 0) ao = 2;
      step("", ao, aa, $urandom, bo, ba, $urandom);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule